// File: doc/BRIEF.md
# Multiplexed Registered Bus Transceiver

This block joins one narrow A port to several B channels of the same width. In the forward direction, data from A is copied to a storage cell in each B channel, and each channel's cell decides on its own when to take it. One shared forward clock enable is routed to a single channel by a route code. In the reverse direction, every B channel has its own storage cell. A pick code chooses one of these cells to drive an internal junction. A further storage cell sits between that junction and the A outputs, so the reverse path can run as a two-stage pipeline.

Each storage cell has two modes, chosen by its controls. While its open (latch-enable) level is high, it is transparent. When that level is low, it is an edge-loaded register with an active-low hold. The external strobe and open pins are not clocks. They are sampled by the single system clock, and their edges are found by comparing each sample with the one before it. Tri-state pins appear as a data bus plus an active-high drive flag, so a pad ring can make the real three-state drivers.

Top module: `mrx_xcvr`

## Requirements
- R1: With every forward open bit high, B channel i output (bits i*W upward of `b_dout`) equals `a_din` for all channels at once.
- R2: While a cell's open input is high, its output follows its data input two system clock edges after the pins change, and strobes have no effect on it.
- R3: When a cell's open input goes from high to low, the cell keeps the value taken while it was open, even if its data input changes in the same cycle.
- R4: When a cell's open input is low and its hold input is 0, a rising strobe loads the cell. A rising strobe while hold is 1 leaves the cell unchanged.
- R5: `fwd_route` value i gives the shared `fwd_hold_n` to forward channel i only. The other forward channels ignore the strobe.
- R6: The reverse B cells share `rev_strobe` and `rev_hold_n`, and each has its own bit of `rev_open`. `rev_pick` value i puts reverse channel i (bits i*W upward of `b_din`) onto the internal junction.
- R7: The junction feeds an output cell, controlled by `rev_out_open` and `rev_out_hold_n` and strobed by `rev_strobe`, that drives `a_dout`. With all cells open, a B input reaches `a_dout` after three edges. With all cells in register mode, a single strobe moves data forward one stage.
- R8: `a_drive` is 1 one edge after `en_a_n` is sampled low, and 0 otherwise.
- R9: `b_drive[i]` is 1 one edge after both `en_b_all_n` and `en_b_ch_n[i]` are sampled low, and 0 otherwise.
- R10: If a cell sees its open falling edge and a rising strobe in the same sample, it holds and ignores the strobe.
- R11: Synchronous reset clears every cell and both drive outputs to zero.
- R12: A strobe held high loads only once. A load needs a new low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | W | A port input data |
| b_din | input | NCH*W | B channel input data, channel i at bits i*W |
| en_a_n | input | 1 | Active-low A output enable |
| en_b_all_n | input | 1 | Active-low enable for all B channels |
| en_b_ch_n | input | NCH | Active-low enable per B channel |
| fwd_strobe | input | 1 | Forward strobe pin, loads on rise |
| fwd_hold_n | input | 1 | Shared forward active-low clock enable |
| fwd_route | input | SELW | Channel that receives fwd_hold_n |
| fwd_open | input | NCH | Forward latch-enable per channel |
| rev_strobe | input | 1 | Reverse strobe pin, loads on rise |
| rev_hold_n | input | 1 | Active-low clock enable of the reverse B cells |
| rev_open | input | NCH | Reverse latch-enable per B cell |
| rev_pick | input | SELW | Reverse channel placed on the junction |
| rev_out_open | input | 1 | Latch-enable of the A output cell |
| rev_out_hold_n | input | 1 | Active-low clock enable of the A output cell |
| a_dout | output | W | A port output data |
| a_drive | output | 1 | A port drive flag |
| b_dout | output | NCH*W | B channel output data |
| b_drive | output | NCH | B channel drive flags |

## Verification
Two functions can land in the same cycle: a cell's open level falling and a rising strobe. The bench sets up this collision by changing the open pin, the strobe pin and the data input on one falling clock edge, so all three are sampled together. It then expects the cell to keep the value from its open phase, not the new data. A second same-cycle case is in the reverse path, where one strobe loads the B cells and the output cell together. The bench checks that `a_dout` first shows the junction's old value and shows the new data only after a second strobe.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  // control bundle handed to one storage cell, already aligned to one sample
  typedef struct packed {
    logic open_lvl;
    logic open_fall;
    logic strobe_rise;
    logic hold_n;
  } cell_ctl_t;
endpackage

// File: rtl/mrx_sampler.sv
module mrx_sampler #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      prv <= '0;
    end else begin
      cur <= pin;
      prv <= cur;
    end
  end
endmodule

// File: rtl/mrx_cell.sv
module mrx_cell
  import mrx_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  cell_ctl_t    ctl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic edge_load;
  assign edge_load = ctl.strobe_rise && !ctl.hold_n && !ctl.open_fall;

  always_ff @(posedge clk) begin
    if (rst)               q <= '0;
    else if (ctl.open_lvl) q <= d;
    else if (edge_load)    q <= d;
  end

  AST_OPEN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ctl.open_lvl |=> q == $past(d)); // R2
  AST_FALL_WINS: assert property (@(posedge clk) disable iff (rst)
    ctl.open_fall |=> $stable(q)); // R10
  AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctl.open_lvl && (ctl.hold_n || !ctl.strobe_rise)) |=> $stable(q)); // R4
  AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!ctl.open_lvl && !ctl.open_fall && ctl.strobe_rise && !ctl.hold_n) |=> q == $past(d)); // R4
endmodule

// File: rtl/mrx_pick.sv
module mrx_pick #(
  parameter int W    = 4,
  parameter int NCH  = 4,
  parameter int SELW = 2
) (
  input  logic [NCH*W-1:0] src,
  input  logic [SELW-1:0]  sel,
  output logic [W-1:0]     dst
);
  always_comb begin
    dst = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == SELW'(i)) dst = src[i*W +: W];
    end
  end
endmodule

// File: rtl/mrx_xcvr.sv
module mrx_xcvr
  import mrx_pkg::*;
#(
  parameter int W    = 4,
  parameter int NCH  = 4,
  parameter int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     a_din,
  input  logic [NCH*W-1:0] b_din,
  input  logic             en_a_n,
  input  logic             en_b_all_n,
  input  logic [NCH-1:0]   en_b_ch_n,
  input  logic             fwd_strobe,
  input  logic             fwd_hold_n,
  input  logic [SELW-1:0]  fwd_route,
  input  logic [NCH-1:0]   fwd_open,
  input  logic             rev_strobe,
  input  logic             rev_hold_n,
  input  logic [NCH-1:0]   rev_open,
  input  logic [SELW-1:0]  rev_pick,
  input  logic             rev_out_open,
  input  logic             rev_out_hold_n,
  output logic [W-1:0]     a_dout,
  output logic             a_drive,
  output logic [NCH*W-1:0] b_dout,
  output logic [NCH-1:0]   b_drive
);
  localparam int NS     = 3 + 2 * NCH;
  localparam int I_FWD  = 0;
  localparam int I_REV  = 1;
  localparam int I_OUT  = 2;
  localparam int I_FOPN = 3;
  localparam int I_ROPN = 3 + NCH;

  // edge-sensitive pins: current and previous samples
  logic [NS-1:0] s_cur, s_prv;
  mrx_sampler #(.N(NS)) u_smp (
    .clk (clk),
    .rst (rst),
    .pin ({rev_open, fwd_open, rev_out_open, rev_strobe, fwd_strobe}),
    .cur (s_cur),
    .prv (s_prv)
  );

  // level-only pins, sampled in the same stage
  logic [W-1:0]     a_s;
  logic [NCH*W-1:0] b_s;
  logic             fhold_s, rhold_s, ohold_s;
  logic [SELW-1:0]  route_s, pick_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_s     <= '0;
      b_s     <= '0;
      fhold_s <= 1'b1;
      rhold_s <= 1'b1;
      ohold_s <= 1'b1;
      route_s <= '0;
      pick_s  <= '0;
      a_drive <= 1'b0;
      b_drive <= '0;
    end else begin
      a_s     <= a_din;
      b_s     <= b_din;
      fhold_s <= fwd_hold_n;
      rhold_s <= rev_hold_n;
      ohold_s <= rev_out_hold_n;
      route_s <= fwd_route;
      pick_s  <= rev_pick;
      a_drive <= ~en_a_n;
      b_drive <= ~(en_b_ch_n | {NCH{en_b_all_n}});
    end
  end

  logic s_fwd_rise, s_rev_rise;
  assign s_fwd_rise = s_cur[I_FWD] & ~s_prv[I_FWD];
  assign s_rev_rise = s_cur[I_REV] & ~s_prv[I_REV];

  logic [NCH-1:0]   fwd_ce_n;
  logic [NCH*W-1:0] rev_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cell_ctl_t fctl, rctl;
    assign fwd_ce_n[i] = (route_s == SELW'(i)) ? fhold_s : 1'b1;

    assign fctl.open_lvl    = s_cur[I_FOPN + i];
    assign fctl.open_fall   = s_prv[I_FOPN + i] & ~s_cur[I_FOPN + i];
    assign fctl.strobe_rise = s_fwd_rise;
    assign fctl.hold_n      = fwd_ce_n[i];

    assign rctl.open_lvl    = s_cur[I_ROPN + i];
    assign rctl.open_fall   = s_prv[I_ROPN + i] & ~s_cur[I_ROPN + i];
    assign rctl.strobe_rise = s_rev_rise;
    assign rctl.hold_n      = rhold_s;

    mrx_cell #(.W(W)) u_fwd (
      .clk (clk), .rst (rst), .ctl (fctl), .d (a_s), .q (b_dout[i*W +: W])
    );
    mrx_cell #(.W(W)) u_rev (
      .clk (clk), .rst (rst), .ctl (rctl), .d (b_s[i*W +: W]), .q (rev_q[i*W +: W])
    );
  end

  logic [W-1:0] junction;
  mrx_pick #(.W(W), .NCH(NCH), .SELW(SELW)) u_pick (
    .src (rev_q), .sel (pick_s), .dst (junction)
  );

  cell_ctl_t octl;
  assign octl.open_lvl    = s_cur[I_OUT];
  assign octl.open_fall   = s_prv[I_OUT] & ~s_cur[I_OUT];
  assign octl.strobe_rise = s_rev_rise;
  assign octl.hold_n      = ohold_s;

  mrx_cell #(.W(W)) u_out (
    .clk (clk), .rst (rst), .ctl (octl), .d (junction), .q (a_dout)
  );

  AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(~fwd_ce_n) <= 1); // R5
  AST_A_DRIVE_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_drive == !$past(en_a_n)); // R8
  AST_B_DRIVE_GATE: assert property (@(posedge clk) disable iff (rst)
    $past(en_b_all_n) |-> b_drive == '0); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (a_dout == '0 && b_dout == '0 && !a_drive && b_drive == '0)); // R11
endmodule

// File: tb/mrx_xcvr_tb.sv
`timescale 1ns/1ps
module mrx_xcvr_tb_top;
  localparam int W = 4, NCH = 4, SELW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] a_din = '0;
  logic [NCH*W-1:0] b_din = '0;
  logic en_a_n = 1'b1, en_b_all_n = 1'b1;
  logic [NCH-1:0] en_b_ch_n = '1;
  logic fwd_strobe = 1'b0, fwd_hold_n = 1'b1;
  logic [SELW-1:0] fwd_route = '0;
  logic [NCH-1:0] fwd_open = '0;
  logic rev_strobe = 1'b0, rev_hold_n = 1'b1;
  logic [NCH-1:0] rev_open = '0;
  logic [SELW-1:0] rev_pick = '0;
  logic rev_out_open = 1'b0, rev_out_hold_n = 1'b1;
  logic [W-1:0] a_dout;
  logic a_drive;
  logic [NCH*W-1:0] b_dout;
  logic [NCH-1:0] b_drive;

  int checks = 0, errors = 0;
  logic [W-1:0] fexp [NCH];

  always #5 clk = ~clk;

  mrx_xcvr #(.W(W), .NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .a_din(a_din), .b_din(b_din), .en_a_n(en_a_n),
    .en_b_all_n(en_b_all_n), .en_b_ch_n(en_b_ch_n), .fwd_strobe(fwd_strobe),
    .fwd_hold_n(fwd_hold_n), .fwd_route(fwd_route), .fwd_open(fwd_open),
    .rev_strobe(rev_strobe), .rev_hold_n(rev_hold_n), .rev_open(rev_open),
    .rev_pick(rev_pick), .rev_out_open(rev_out_open), .rev_out_hold_n(rev_out_hold_n),
    .a_dout(a_dout), .a_drive(a_drive), .b_dout(b_dout), .b_drive(b_drive)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fpack();
    logic [15:0] v;
    for (int i = 0; i < NCH; i++) v[i*W +: W] = fexp[i];
    return v;
  endfunction

  task automatic fwd_pulse();
    fwd_strobe = 1'b1; tick(1); fwd_strobe = 1'b0; tick(3);
  endtask

  task automatic rev_pulse();
    rev_strobe = 1'b1; tick(1); rev_strobe = 1'b0; tick(3);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R11: reset state
    chk("R11", {a_dout, 3'b0, a_drive, b_drive, 4'b0}, 16'h0);
    chk("R11", b_dout, 16'h0);
    rst = 1'b0;
    tick(2);

    // R9: all enable combinations
    for (int m = 0; m < 32; m++) begin
      en_b_all_n = m[4];
      en_b_ch_n  = m[3:0];
      tick(2);
      chk("R9", {12'b0, b_drive}, m[4] ? 16'h0 : {12'b0, ~m[3:0]});
    end
    // R8
    for (int m = 0; m < 2; m++) begin
      en_a_n = m[0];
      tick(2);
      chk("R8", {15'b0, a_drive}, {15'b0, ~m[0]});
    end

    // R1/R2: transparent fan-out over every A value, strobe toggling
    fwd_open = '1; fwd_hold_n = 1'b0;
    for (int v = 0; v < 16; v++) begin
      a_din = v[3:0];
      fwd_strobe = v[0];
      tick(3);
      chk("R1", b_dout, {4{v[3:0]}});
    end
    fwd_strobe = 1'b0; fwd_hold_n = 1'b1;

    // R3: fall with simultaneous data change keeps open-phase value
    a_din = 4'h5; tick(3);
    fwd_open = '0; a_din = 4'hA; tick(4);
    chk("R3", b_dout, 16'h5555);
    for (int i = 0; i < NCH; i++) fexp[i] = 4'h5;

    // R5/R4: route shared enable to each channel in turn
    fwd_hold_n = 1'b0;
    for (int r = 0; r < NCH; r++) begin
      fwd_route = r[1:0];
      a_din = 4'(r + 8);
      fwd_pulse();
      fexp[r] = 4'(r + 8);
      chk("R5", b_dout, fpack());
    end
    fwd_hold_n = 1'b1; a_din = 4'h3; fwd_route = 2'd2;
    fwd_pulse();
    chk("R4", b_dout, fpack());

    // R12: strobe held high loads once
    fwd_hold_n = 1'b0; fwd_route = 2'd0; a_din = 4'h1;
    fwd_strobe = 1'b1; tick(3);
    fexp[0] = 4'h1;
    chk("R12", b_dout, fpack());
    a_din = 4'h2; tick(3);
    chk("R12", b_dout, fpack());
    fwd_strobe = 1'b0; tick(2);

    // R10: open fall and strobe rise in the same sample
    fwd_route = 2'd1; fwd_open = 4'b0010; a_din = 4'h6; tick(3);
    fexp[1] = 4'h6;
    fwd_open = '0; fwd_strobe = 1'b1; a_din = 4'h9; tick(4);
    chk("R10", b_dout, fpack());
    fwd_strobe = 1'b0; fwd_hold_n = 1'b1; tick(2);

    // R6/R7: transparent reverse path, all picks, several patterns
    rev_open = '1; rev_out_open = 1'b1;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < NCH; i++) b_din[i*W +: W] = 4'(k * 3 + i * 5 + 1);
      for (int p = 0; p < NCH; p++) begin
        rev_pick = p[1:0];
        tick(4);
        chk("R6", {12'b0, a_dout}, {12'b0, 4'(k * 3 + p * 5 + 1)});
      end
    end

    // R7: output cell in register mode
    rev_pick = 2'd2; b_din = 16'h0700; tick(3);
    rev_out_open = 1'b0; rev_out_hold_n = 1'b0; tick(2);
    rev_pulse();
    chk("R7", {12'b0, a_dout}, 16'h0007);
    b_din = 16'h0C00; tick(3);
    rev_out_hold_n = 1'b1;
    rev_pulse();
    chk("R4", {12'b0, a_dout}, 16'h0007);

    // R7: both stages registered, one stage per strobe
    rev_out_hold_n = 1'b0; rev_open = '0; rev_hold_n = 1'b0; tick(2);
    b_din = 16'hEEEE; tick(1);
    rev_pulse();
    chk("R7", {12'b0, a_dout}, 16'h000C);
    rev_pulse();
    chk("R7", {12'b0, a_dout}, 16'h000E);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule